// File: doc/BRIEF.md
# Quarter-Duty LCD Waveform Sequencer

This block produces the time-multiplexed drive codes for a passive LCD panel with four common electrodes and twenty-two segment electrodes, which gives 88 addressable dots. It scans the four commons in turn. Each common's time slot is split into two halves of opposite polarity, so the voltage across every dot averages to zero over a frame. For each pin it emits a 2-bit level code. An analog stage outside this block turns that code into one of the bias voltages.

The frame timing comes from a one-cycle tick enable at oscillator rate. Each common slot lasts `PHASE_TICKS` ticks, and a frame lasts four slots. Bias is selected at run time, either one-third or one-half. A blanking flag turns every segment off while the commons keep scanning. A power-save flag grounds every output and freezes the scan. An active-low inhibit input grounds the panel and takes back any pins that were lent out as general-purpose outputs. A port-count field can hand up to four of the leading segment pins over to logic outputs. Each such output carries the first dot bit of its own segment.

Top module: `lcdq_sequencer`

## Requirements
- R1: The selected common advances 0,1,2,3,0,... and stays selected for `PHASE_TICKS` tick enables. A full frame is therefore 4*`PHASE_TICKS` ticks. After reset the scan starts at common 0 in the first half.
- R2: The first `PHASE_TICKS`/2 ticks of each slot use polarity A and the rest use polarity B. In polarity A a selected common is full (code 3) and an on segment is ground (code 0). In polarity B both are inverted: the selected common is ground and an on segment is full.
- R3: Level codes are 0 = ground, 1 = one-third, 2 = two-thirds, 3 = full. With one-third bias (`halfBias`=0), an unselected common is code 1 in polarity A and code 2 in polarity B. An off segment is code 2 in polarity A and code 1 in polarity B. Exactly one common is at an extreme level while driving.
- R4: With half bias (`halfBias`=1), code 1 means half supply. Unselected commons and off segments are code 1 in both polarities. Selected commons and on segments follow R2.
- R5: Segment k (0-based) is on during common c when `dispBits[4*k+c]` is 1.
- R6: While `segBlank`=1, every segment pin shows the off level and the commons keep scanning.
- R7: The pin count is `portSel` when it is 0 to 4, and 4 when it is 5 to 7. That many leading segment pins, starting at pin 0, act as ports. For such a pin m, `portMode[m]`=1, its segment code is 0, and `portOut[m]`=`dispBits[4*m]`. Pins beyond the count have `portMode`=0 and `portOut`=0.
- R8: While `inhibitN`=0, every common and segment code is 0, and `portMode` and `portOut` are all 0. The scan keeps running.
- R9: While `powerSave`=1, every common and segment code is 0 and `portOut` is 0. The scan position is frozen, and `portMode` still follows R7 when `inhibitN`=1.
- R10: During reset every output is 0.
- R11: All outputs are registered. A change of any input, or of the scan position, shows at the outputs one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Oscillator-rate tick, one clock wide |
| dispBits | input | 4*NUM_SEG | Dot bits, bit 4*k+c = segment k at common c |
| halfBias | input | 1 | 1 = half bias, 0 = one-third bias |
| segBlank | input | 1 | Force all segments off |
| powerSave | input | 1 | Ground all outputs, freeze scan |
| portSel | input | 3 | Number of leading pins used as ports |
| inhibitN | input | 1 | Active-low display inhibit |
| comLevel | output | 8 | Level code per common, common c at bits 2c+1:2c |
| segLevel | output | 2*NUM_SEG | Level code per segment pin, pin k at bits 2k+1:2k |
| portMode | output | NUM_PORT | Pin m acts as a logic port |
| portOut | output | NUM_PORT | Logic value for pins in port mode |

## Verification
Inhibit and power-save can both be active in the same cycle. They overlap in what they ground, but they differ in two ways: whether the scan advances and whether the port assignment survives. The bench toggles both inputs on the same clock, and separately toggles each one alone, with a non-zero port count and ticks running. A behavioural model tracks the scan position and predicts every output on every clock. A wrong precedence therefore shows up either as a shifted common after release or as a wrong `portMode` during the overlap.

// File: rtl/lcdq_pkg.sv
package lcdq_pkg;

  localparam int COM_COUNT  = 4;
  localparam int COM_IDX_W  = 2;
  localparam int PORT_CNT_W = 3;

  typedef enum logic [1:0] {
    LVL_GND  = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_FULL = 2'd3
  } level_e;

  // strobes from the scan control to the level datapath
  typedef struct packed {
    logic [COM_IDX_W-1:0]  comIdx;
    logic                  polarity;
    logic                  driveOn;
    logic                  portsLegal;
    logic                  halfBias;
    logic                  blankSeg;
    logic [PORT_CNT_W-1:0] portCount;
  } drvStrobe_t;

endpackage

// File: rtl/lcdq_scan_ctrl.sv
module lcdq_scan_ctrl
  import lcdq_pkg::*;
#(
  parameter int PHASE_TICKS = 128,
  parameter int NUM_PORT    = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tickEn,
  input  logic                  powerSave,
  input  logic                  inhibitN,
  input  logic                  halfBias,
  input  logic                  segBlank,
  input  logic [PORT_CNT_W-1:0] portSel,
  output drvStrobe_t            strb
);

  localparam int HALF_TICKS = PHASE_TICKS / 2;
  localparam int SUB_W      = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [SUB_W-1:0]      SUB_LAST = SUB_W'(HALF_TICKS - 1);
  localparam logic [PORT_CNT_W-1:0] PORT_MAX = PORT_CNT_W'(NUM_PORT);

  logic [SUB_W-1:0]     subCnt;
  logic                 polQ;
  logic [COM_IDX_W-1:0] comQ;
  logic                 stepEn;
  logic                 halfEnd;

  assign stepEn  = tickEn && !powerSave;
  assign halfEnd = (subCnt == SUB_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subCnt <= '0;
      polQ   <= 1'b0;
      comQ   <= '0;
    end else if (stepEn) begin
      if (halfEnd) begin
        subCnt <= '0;
        polQ   <= ~polQ;
        if (polQ) comQ <= comQ + 1'b1;
      end else begin
        subCnt <= subCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.comIdx     = comQ;
    strb.polarity   = polQ;
    strb.driveOn    = inhibitN && !powerSave;
    strb.portsLegal = inhibitN;
    strb.halfBias   = halfBias;
    strb.blankSeg   = segBlank;
    strb.portCount  = (portSel > PORT_MAX) ? PORT_MAX : portSel;
  end

  // R1: sub-count never leaves the half-slot range
  p_sub_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    subCnt <= SUB_LAST);

  // R1: the end of polarity B moves to the next common
  p_com_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && halfEnd && polQ) |=> (comQ == $past(comQ) + 1'b1));

  // R2: polarity flips at every half-slot boundary
  p_pol_flip_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && halfEnd) |=> (polQ != $past(polQ)));

  // R9: scan position frozen in power save
  p_freeze_r9: assert property (@(posedge clk) disable iff (!rstN)
    powerSave |=> ($stable(subCnt) && $stable(polQ) && $stable(comQ)));

endmodule

// File: rtl/lcdq_level_dp.sv
module lcdq_level_dp
  import lcdq_pkg::*;
#(
  parameter int NUM_SEG  = 22,
  parameter int NUM_PORT = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  drvStrobe_t                    strb,
  input  logic [COM_COUNT*NUM_SEG-1:0]  dispBits,
  output logic [2*COM_COUNT-1:0]        comLevel,
  output logic [2*NUM_SEG-1:0]          segLevel,
  output logic [NUM_PORT-1:0]           portMode,
  output logic [NUM_PORT-1:0]           portOut
);

  function automatic level_e comCode(input logic sel, input logic pol, input logic half);
    if (sel) return pol ? LVL_GND : LVL_FULL;
    return (half || !pol) ? LVL_LOW : LVL_HIGH;
  endfunction

  function automatic level_e segCode(input logic on, input logic pol, input logic half);
    if (on) return pol ? LVL_FULL : LVL_GND;
    if (half) return LVL_LOW;
    return pol ? LVL_LOW : LVL_HIGH;
  endfunction

  logic [2*COM_COUNT-1:0] comNext;
  logic [2*NUM_SEG-1:0]   segNext;
  logic [NUM_PORT-1:0]    modeNext;
  logic [NUM_PORT-1:0]    outNext;

  for (genvar c = 0; c < COM_COUNT; c++) begin : g_com
    localparam logic [COM_IDX_W-1:0] MY_COM = COM_IDX_W'(c);
    assign comNext[2*c +: 2] = strb.driveOn
                             ? comCode(strb.comIdx == MY_COM, strb.polarity, strb.halfBias)
                             : LVL_GND;
  end

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    logic [COM_COUNT-1:0] segDots;
    logic                 dotOn;
    logic                 pinIsPort;
    assign segDots = dispBits[k*COM_COUNT +: COM_COUNT];
    assign dotOn   = segDots[strb.comIdx] && !strb.blankSeg;
    if (k < NUM_PORT) begin : g_shared
      localparam logic [PORT_CNT_W-1:0] PIN_IDX = PORT_CNT_W'(k);
      assign pinIsPort   = strb.portsLegal && (PIN_IDX < strb.portCount);
      assign modeNext[k] = pinIsPort;
      assign outNext[k]  = pinIsPort && strb.driveOn && segDots[0];
    end else begin : g_plain
      assign pinIsPort = 1'b0;
    end
    assign segNext[2*k +: 2] = (strb.driveOn && !pinIsPort)
                             ? segCode(dotOn, strb.polarity, strb.halfBias)
                             : LVL_GND;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      comLevel <= '0;
      segLevel <= '0;
      portMode <= '0;
      portOut  <= '0;
    end else begin
      comLevel <= comNext;
      segLevel <= segNext;
      portMode <= modeNext;
      portOut  <= outNext;
    end
  end

  // observation helpers for the checks below
  logic [COM_COUNT-1:0] comExtreme;
  logic [NUM_SEG-1:0]   segMid;
  for (genvar c = 0; c < COM_COUNT; c++) begin : g_obsCom
    assign comExtreme[c] = (comLevel[2*c +: 2] == LVL_GND) || (comLevel[2*c +: 2] == LVL_FULL);
  end
  for (genvar k = 0; k < NUM_SEG; k++) begin : g_obsSeg
    assign segMid[k] = (segLevel[2*k +: 2] == LVL_LOW) || (segLevel[2*k +: 2] == LVL_HIGH);
  end

  // R3: exactly one common at an extreme level while driving
  p_single_select_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.driveOn |=> ($countones(comExtreme) == 1));

  // R6: blanking leaves every segment pin at a mid level
  p_blank_mid_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.blankSeg && strb.driveOn && strb.portCount == '0) |=> (&segMid));

  // R8: inhibit grounds everything and releases the ports
  p_inhibit_dark_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.portsLegal |=> (comLevel == '0 && segLevel == '0 && portMode == '0 && portOut == '0));

  // R7: port pins always form a leading run
  p_port_prefix_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((portMode & (portMode + 1'b1)) == '0));

endmodule

// File: rtl/lcdq_sequencer.sv
module lcdq_sequencer
  import lcdq_pkg::*;
#(
  parameter int NUM_SEG     = 22,
  parameter int NUM_PORT    = 4,
  parameter int PHASE_TICKS = 128
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          tickEn,
  input  logic [COM_COUNT*NUM_SEG-1:0]  dispBits,
  input  logic                          halfBias,
  input  logic                          segBlank,
  input  logic                          powerSave,
  input  logic [PORT_CNT_W-1:0]         portSel,
  input  logic                          inhibitN,
  output logic [2*COM_COUNT-1:0]        comLevel,
  output logic [2*NUM_SEG-1:0]          segLevel,
  output logic [NUM_PORT-1:0]           portMode,
  output logic [NUM_PORT-1:0]           portOut
);

  drvStrobe_t strb;

  lcdq_scan_ctrl #(
    .PHASE_TICKS (PHASE_TICKS),
    .NUM_PORT    (NUM_PORT)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .powerSave (powerSave),
    .inhibitN  (inhibitN),
    .halfBias  (halfBias),
    .segBlank  (segBlank),
    .portSel   (portSel),
    .strb      (strb)
  );

  lcdq_level_dp #(
    .NUM_SEG  (NUM_SEG),
    .NUM_PORT (NUM_PORT)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .dispBits (dispBits),
    .comLevel (comLevel),
    .segLevel (segLevel),
    .portMode (portMode),
    .portOut  (portOut)
  );

endmodule

// File: tb/test_lcdq_sequencer.sv
module test_lcdq_sequencer;

  localparam int NSEG  = 22;
  localparam int NPORT = 4;
  localparam int HALF  = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic [4*NSEG-1:0] dispBits = '0;
  logic halfBias = 1'b0;
  logic segBlank = 1'b0;
  logic powerSave = 1'b0;
  logic [2:0] portSel = 3'd0;
  logic inhibitN = 1'b1;
  logic [7:0] comLevel;
  logic [2*NSEG-1:0] segLevel;
  logic [NPORT-1:0] portMode, portOut;

  always #2.5 clk = ~clk;

  lcdq_sequencer i_lcdq_sequencer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .dispBits(dispBits),
    .halfBias(halfBias), .segBlank(segBlank), .powerSave(powerSave),
    .portSel(portSel), .inhibitN(inhibitN), .comLevel(comLevel),
    .segLevel(segLevel), .portMode(portMode), .portOut(portOut));

  int checks = 0;
  int errors = 0;
  string curReq = "R10";
  int tickMode = 0;
  int cyc = 0;
  bit compareOn = 1'b0;

  // behavioural model
  int mSub = 0, mPol = 0, mCom = 0;
  logic [7:0] expCom = '0;
  logic [2*NSEG-1:0] expSeg = '0;
  logic [NPORT-1:0] expMode = '0, expOut = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mSub = 0; mPol = 0; mCom = 0;
      expCom = '0; expSeg = '0; expMode = '0; expOut = '0;
    end else begin
      bit drive;
      int pc;
      drive = inhibitN && !powerSave;
      pc = (portSel > 3'd4) ? 4 : int'(portSel);
      for (int c = 0; c < 4; c++) begin
        int v;
        if (!drive) v = 0;
        else if (c == mCom) v = mPol ? 0 : 3;
        else v = halfBias ? 1 : (mPol ? 2 : 1);
        expCom[2*c +: 2] = 2'(v);
      end
      for (int k = 0; k < NSEG; k++) begin
        int v;
        bit isPort;
        isPort = inhibitN && (k < pc);
        if (!drive || isPort) v = 0;
        else if (dispBits[4*k + mCom] && !segBlank) v = mPol ? 3 : 0;
        else v = halfBias ? 1 : (mPol ? 1 : 2);
        expSeg[2*k +: 2] = 2'(v);
      end
      for (int m = 0; m < NPORT; m++) begin
        expMode[m] = inhibitN && (m < pc);
        expOut[m]  = expMode[m] && drive && dispBits[4*m];
      end
      if (tickEn && !powerSave) begin
        mSub++;
        if (mSub == HALF) begin
          mSub = 0;
          if (mPol == 1) begin mPol = 0; mCom = (mCom + 1) % 4; end
          else mPol = 1;
        end
      end
    end
  end

  // tick pattern and every-clock comparison (R11 latency covered here)
  always @(negedge clk) begin
    cyc++;
    case (tickMode)
      0: tickEn <= 1'b1;
      1: tickEn <= (cyc % 2 == 0);
      default: tickEn <= (cyc % 5 != 1);
    endcase
    if (compareOn) begin
      checks++;
      if (comLevel !== expCom || segLevel !== expSeg || portMode !== expMode || portOut !== expOut) begin
        errors++;
        if (errors < 20)
          $display("FAIL %s t=%0t com %h/%h seg %h/%h mode %b/%b out %b/%b", curReq, $time,
                   comLevel, expCom, segLevel, expSeg, portMode, expMode, portOut, expOut);
      end
    end
  end

  task automatic newDisp();
    logic [95:0] tmp;
    tmp = {$urandom, $urandom, $urandom};
    dispBits = tmp[4*NSEG-1:0];
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    run(4);
    // R10: outputs idle during reset
    checks++;
    if (comLevel !== '0 || segLevel !== '0 || portMode !== '0 || portOut !== '0) begin
      errors++;
      $display("FAIL R10 reset com %h seg %h mode %b out %b, expected all zero", comLevel, segLevel, portMode, portOut);
    end
    rstN = 1'b1;
    compareOn = 1'b1;

    curReq = "R1 R2 R3 R5 R11";
    newDisp();
    run(1100);
    curReq = "R5";
    dispBits = {NSEG{4'b1010}};
    run(300);
    newDisp();
    run(300);

    curReq = "R4";
    halfBias = 1'b1; tickMode = 1;
    run(1200);
    halfBias = 1'b0; tickMode = 2;

    curReq = "R6";
    segBlank = 1'b1;
    run(500);
    halfBias = 1'b1;
    run(300);
    segBlank = 1'b0; halfBias = 1'b0;

    curReq = "R7";
    tickMode = 0;
    for (int ps = 0; ps < 8; ps++) begin
      portSel = 3'(ps);
      newDisp();
      run(150);
    end

    curReq = "R8";
    portSel = 3'd3;
    inhibitN = 1'b0;
    run(700);
    inhibitN = 1'b1;
    run(300);

    curReq = "R9";
    powerSave = 1'b1;
    run(400);
    powerSave = 1'b0;
    run(300);

    curReq = "R8 R9";
    portSel = 3'd6; tickMode = 2;
    for (int i = 0; i < 6; i++) begin
      powerSave = 1'b1; inhibitN = 1'b0;
      run(37 + i);
      inhibitN = 1'b1;
      run(50);
      powerSave = 1'b0; inhibitN = (i % 2 == 0);
      run(90);
      inhibitN = 1'b1;
      run(60);
    end
    run(5);
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

endmodule